// File: doc/BRIEF.md
# Hash Engine Control Register Block

This block is the software-facing front end of a hash accelerator. A host reaches it over a simple 32-bit register bus whose byte address is divided by four to select a word. Through it the host programs where the message lives, where the digest goes and how long the message is. It then writes a command word that names the digest algorithm. A legal command launches a job on a one-cycle start strobe towards the datapath, together with the decoded 3-bit algorithm code and the programmed addresses. The datapath answers with a one-cycle done strobe.

Completion is recorded in a sticky done flag in the status word, whether or not the command asked for an interrupt. The interrupt line follows the done flag only when the launching command enabled it. Software acknowledges by writing 1 to the done flag. While a job runs, the block reports busy and refuses further commands. Illegal algorithm selections and requests for unsupported keyed or chained modes are reported on single-cycle flags.

A build parameter chooses between a full variant and a reduced variant. The reduced variant has no scatter-gather and no 512-family variant selection, and this shows only in the write mask of the command word.

Top module: `hashctl_regs`

## Requirements
- R1: After reset every register word reads 0, `irq` is low and `job_start` is low.
- R2: Writes are masked per word. The source address keeps `SRC_ADDR_MASK` (default 0x7FFFFFFF). The destination keeps the same mask with bits [2:0] forced to 0. The length keeps bits [27:0]. The cipher command word keeps all 32 bits. The hash command keeps 0x00147FFF when `FULL_VARIANT`=1 and 0x000003FF when it is 0.
- R3: The word index is the byte address shifted right by 2. The map is: cipher command 0x10, status 0x1C, source 0x20, destination 0x24, length 0x2C, hash command 0x30. Read data appears on `bus_rdata` in the cycle after the request. Other in-range words read 0. Words at index `NUM_WORDS` (16) and above read 0, and writes to them change no register.
- R4: The algorithm is chosen by the masked command bits [12:10] (variant) and [6:4] (base). Only these pairs are legal, written as base/variant with output codes: 0/0 gives 0 (MD5), 2/0 gives 1 (SHA-1), 4/0 gives 2 (SHA-224), 5/0 gives 3 (SHA-256), 6/0 gives 4 (SHA-512), 6/1 gives 5 (SHA-384), 6/2 gives 6 (SHA-512/256). Any other pair pulses `cmd_err` for one cycle in the cycle after the write and starts no job.
- R5: A legal command write while idle pulses `job_start` for exactly one cycle, in the cycle after the write. In that cycle `job_algo` carries the code and `job_sg` carries masked command bit 18. `job_src`, `job_dst` and `job_len` present the stored register values.
- R6: The status word has done at bit 9 and busy at bit 0, and all other bits read 0. When `job_done` arrives during a job, busy clears and done sets. `irq` rises in the same cycle only if bit 9 of the launching command was 1. `job_done` outside a job is ignored.
- R7: A status write with bit 9 = 1 clears done and lowers `irq`. A status write with bit 9 = 0 changes neither.
- R8: While busy, a hash command write is ignored entirely. The stored command is unchanged, there is no start, and neither flag pulses.
- R9: An accepted command with bits [8:7] not both 0, or with bit 1 set, pulses `cmd_unsup` for one cycle in the cycle after the write. If its algorithm field is legal the job still starts.
- R10: An accepted command write stores the masked value even when its algorithm field is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| job_start | output | 1 | One-cycle launch strobe to the datapath |
| job_algo | output | 3 | Decoded algorithm code |
| job_sg | output | 1 | Scatter-gather request for the job |
| job_src | output | 32 | Source address register |
| job_dst | output | 32 | Destination address register |
| job_len | output | 32 | Source length register |
| job_done | input | 1 | One-cycle completion strobe from the datapath |
| irq | output | 1 | Completion interrupt |
| cmd_err | output | 1 | Illegal algorithm selection flag |
| cmd_unsup | output | 1 | Unsupported mode request flag |

## Verification
The bench builds two copies side by side on one bus. The first uses the defaults: full variant, 16 words, 12-bit byte address and a 31-bit source mask. The second sets `FULL_VARIANT` to 0. On the full copy the bench sweeps all 64 pairs of the two 3-bit algorithm fields, which covers every legal and every illegal encoding. A stalling datapath stub gives access to the busy window. The reduced copy shows the variant and scatter-gather bits being removed by the mask, so a 384 selection there becomes a 512 job with no scatter-gather.

// File: rtl/hashctl_pkg.sv
package hashctl_pkg;

    typedef enum logic [2:0] {
        ALG_MD5        = 3'd0,
        ALG_SHA1       = 3'd1,
        ALG_SHA224     = 3'd2,
        ALG_SHA256     = 3'd3,
        ALG_SHA512     = 3'd4,
        ALG_SHA384     = 3'd5,
        ALG_SHA512_256 = 3'd6,
        ALG_NONE       = 3'd7
    } hash_alg_e;

    // Word indices (byte offset >> 2)
    localparam int unsigned WIDX_CIPHER = 4;
    localparam int unsigned WIDX_STATUS = 7;
    localparam int unsigned WIDX_SRC    = 8;
    localparam int unsigned WIDX_DST    = 9;
    localparam int unsigned WIDX_LEN    = 11;
    localparam int unsigned WIDX_CMD    = 12;

    localparam logic [31:0] LEN_KEEP      = 32'h0FFF_FFFF;
    localparam logic [31:0] CMD_KEEP_FULL = 32'h0014_7FFF;
    localparam logic [31:0] CMD_KEEP_LITE = 32'h0000_03FF;

    localparam int unsigned CMD_IRQ_EN_BIT = 9;
    localparam int unsigned CMD_SG_BIT     = 18;
    localparam int unsigned STAT_DONE_BIT  = 9;
    localparam int unsigned STAT_BUSY_BIT  = 0;

    typedef struct packed {
        logic busy;
        logic done;
        logic irq;
        logic start;
        logic irq_en;
    } job_state_t;

    typedef struct packed {
        logic [31:0] cipher;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
        logic [31:0] cmd;
        logic [31:0] rdata;
        hash_alg_e   alg;
        logic        sg;
        logic        err;
        logic        unsup;
    } regs_t;

endpackage

// File: rtl/hashctl_addr_dec.sv
module hashctl_addr_dec #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 16
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [ADDR_W-3:0]   word_o,
    output logic                in_range_o
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] shifted;

    always_comb begin
        shifted    = addr_i >> 2;
        word_o     = shifted[WORD_W-1:0];
        in_range_o = (shifted < ADDR_W'(NUM_WORDS));
    end
endmodule

// File: rtl/hashctl_alg_dec.sv
module hashctl_alg_dec
    import hashctl_pkg::*;
(
    input  logic [2:0] base_i,     // command bits [6:4]
    input  logic [2:0] variant_i,  // command bits [12:10]
    input  logic [1:0] keyed_i,    // command bits [8:7]
    input  logic       chain_i,    // command bit 1
    output logic       legal_o,
    output hash_alg_e  alg_o,
    output logic       unsup_o
);
    always_comb begin
        legal_o = 1'b1;
        alg_o   = ALG_NONE;
        case ({variant_i, base_i})
            6'b000_000: alg_o = ALG_MD5;
            6'b000_010: alg_o = ALG_SHA1;
            6'b000_100: alg_o = ALG_SHA224;
            6'b000_101: alg_o = ALG_SHA256;
            6'b000_110: alg_o = ALG_SHA512;
            6'b001_110: alg_o = ALG_SHA384;
            6'b010_110: alg_o = ALG_SHA512_256;
            default: begin
                legal_o = 1'b0;
                alg_o   = ALG_NONE;
            end
        endcase
        unsup_o = (|keyed_i) | chain_i;
    end
endmodule

// File: rtl/hashctl_job_ctrl.sv
module hashctl_job_ctrl
    import hashctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic irq_en_i,
    input  logic done_i,
    input  logic clr_i,
    output logic busy_o,
    output logic done_o,
    output logic irq_o,
    output logic start_o
);
    job_state_t s_d, s_q;
    logic       finish;

    always_comb begin
        s_d       = s_q;
        s_d.start = launch_i;
        finish    = s_q.busy & done_i;

        if (launch_i) begin
            s_d.busy   = 1'b1;
            s_d.irq_en = irq_en_i;
        end else if (finish) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            if (s_q.irq_en) begin
                s_d.irq = 1'b1;
            end
        end

        // A fresh completion outranks a same-cycle acknowledge
        if (clr_i && !finish) begin
            s_d.done = 1'b0;
            s_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = s_q.busy;
    assign done_o  = s_q.done;
    assign irq_o   = s_q.irq;
    assign start_o = s_q.start;
endmodule

// File: rtl/hashctl_regs.sv
module hashctl_regs
    import hashctl_pkg::*;
#(
    parameter bit          FULL_VARIANT  = 1'b1,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned NUM_WORDS     = 16,
    parameter logic [31:0] SRC_ADDR_MASK = 32'h7FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              job_start,
    output logic [2:0]        job_algo,
    output logic              job_sg,
    output logic [31:0]       job_src,
    output logic [31:0]       job_dst,
    output logic [31:0]       job_len,
    input  logic              job_done,
    output logic              irq,
    output logic              cmd_err,
    output logic              cmd_unsup
);
    localparam int unsigned WORD_W   = ADDR_W - 2;
    localparam logic [31:0] CMD_KEEP = FULL_VARIANT ? CMD_KEEP_FULL : CMD_KEEP_LITE;
    localparam logic [31:0] DST_KEEP = SRC_ADDR_MASK & ~32'h7;

    regs_t r_d, r_q;

    logic [WORD_W-1:0] word;
    logic              in_range;
    logic              wr_any;
    logic              rd_any;
    logic [31:0]       cmd_new;
    logic              alg_legal;
    hash_alg_e         alg_code;
    logic              alg_unsup;
    logic              busy;
    logic              done_flag;
    logic              cmd_take;
    logic              launch;
    logic              clr_done;
    logic [31:0]       status_val;
    logic [31:0]       rd_val;

    hashctl_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_adec (
        .addr_i     (bus_addr),
        .word_o     (word),
        .in_range_o (in_range)
    );

    assign cmd_new = bus_wdata & CMD_KEEP;

    hashctl_alg_dec u_adc (
        .base_i    (cmd_new[6:4]),
        .variant_i (cmd_new[12:10]),
        .keyed_i   (cmd_new[8:7]),
        .chain_i   (cmd_new[1]),
        .legal_o   (alg_legal),
        .alg_o     (alg_code),
        .unsup_o   (alg_unsup)
    );

    always_comb begin
        wr_any   = bus_valid & bus_write & in_range;
        rd_any   = bus_valid & ~bus_write;
        cmd_take = wr_any & (word == WORD_W'(WIDX_CMD)) & ~busy;
        launch   = cmd_take & alg_legal;
        clr_done = wr_any & (word == WORD_W'(WIDX_STATUS)) & bus_wdata[STAT_DONE_BIT];
    end

    hashctl_job_ctrl u_job (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .irq_en_i (cmd_new[CMD_IRQ_EN_BIT]),
        .done_i   (job_done),
        .clr_i    (clr_done),
        .busy_o   (busy),
        .done_o   (done_flag),
        .irq_o    (irq),
        .start_o  (job_start)
    );

    // Read view
    always_comb begin
        status_val                = '0;
        status_val[STAT_DONE_BIT] = done_flag;
        status_val[STAT_BUSY_BIT] = busy;

        rd_val = '0;
        if (in_range) begin
            if (word == WORD_W'(WIDX_CIPHER))      rd_val = r_q.cipher;
            else if (word == WORD_W'(WIDX_STATUS)) rd_val = status_val;
            else if (word == WORD_W'(WIDX_SRC))    rd_val = r_q.src;
            else if (word == WORD_W'(WIDX_DST))    rd_val = r_q.dst;
            else if (word == WORD_W'(WIDX_LEN))    rd_val = r_q.len;
            else if (word == WORD_W'(WIDX_CMD))    rd_val = r_q.cmd;
            else                                   rd_val = '0;
        end
    end

    // Next-state of the register file
    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        r_d.unsup = 1'b0;

        if (wr_any) begin
            if (word == WORD_W'(WIDX_CIPHER)) r_d.cipher = bus_wdata;
            if (word == WORD_W'(WIDX_SRC))    r_d.src    = bus_wdata & SRC_ADDR_MASK;
            if (word == WORD_W'(WIDX_DST))    r_d.dst    = bus_wdata & DST_KEEP;
            if (word == WORD_W'(WIDX_LEN))    r_d.len    = bus_wdata & LEN_KEEP;
        end

        if (cmd_take) begin
            r_d.cmd   = cmd_new;
            r_d.err   = ~alg_legal;
            r_d.unsup = alg_unsup;
            if (alg_legal) begin
                r_d.alg = alg_code;
                r_d.sg  = cmd_new[CMD_SG_BIT];
            end
        end

        if (rd_any) begin
            r_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
    assign job_algo  = r_q.alg;
    assign job_sg    = r_q.sg;
    assign job_src   = r_q.src;
    assign job_dst   = r_q.dst;
    assign job_len   = r_q.len;
    assign cmd_err   = r_q.err;
    assign cmd_unsup = r_q.unsup;
endmodule

// File: rtl/hashctl_regs_chk.sv
module hashctl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       job_start,
    input logic [2:0] job_algo,
    input logic       job_done,
    input logic       irq,
    input logic       busy,
    input logic       done_flag,
    input logic       clr_done
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start);                                   // R5

    AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> busy);                                         // R5

    AST_START_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> (job_algo != 3'd7));                           // R4

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !job_done) |=> !job_start);                         // R8

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);                                          // R6

    AST_IRQ_RISES_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(busy && job_done));                     // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !(busy && job_done)) |=> (!done_flag && !irq)); // R7
endmodule

bind hashctl_regs hashctl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .job_start (job_start),
    .job_algo  (job_algo),
    .job_done  (job_done),
    .irq       (irq),
    .busy      (busy),
    .done_flag (done_flag),
    .clr_done  (clr_done)
);

// File: tb/hashctl_regs_tb_top.sv
`timescale 1ns/1ps
module hashctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;

    logic [31:0] rdata_f, rdata_r;
    logic        start_f, start_r;
    logic [2:0]  algo_f, algo_r;
    logic        sg_f, sg_r;
    logic [31:0] src_f, dst_f, len_f;
    logic [31:0] src_r, dst_r, len_r;
    logic        done_f = 1'b0;
    logic        done_r = 1'b0;
    logic        irq_f, irq_r;
    logic        err_f, err_r, uns_f, uns_r;

    int n_chk  = 0;
    int n_fail = 0;
    bit stub_hold = 1'b0;
    int stub_cnt = 0;

    always #10 clk = ~clk;

    hashctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_f),
        .job_start(start_f), .job_algo(algo_f), .job_sg(sg_f),
        .job_src(src_f), .job_dst(dst_f), .job_len(len_f),
        .job_done(done_f), .irq(irq_f), .cmd_err(err_f), .cmd_unsup(uns_f)
    );

    hashctl_regs #(.FULL_VARIANT(1'b0)) dut_red_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_r),
        .job_start(start_r), .job_algo(algo_r), .job_sg(sg_r),
        .job_src(src_r), .job_dst(dst_r), .job_len(len_r),
        .job_done(done_r), .irq(irq_r), .cmd_err(err_r), .cmd_unsup(uns_r)
    );

    // Datapath stubs: full copy answers three cycles after start (can stall),
    // reduced copy answers one cycle after start.
    always @(negedge clk) begin
        done_f = 1'b0;
        done_r = start_r;
        if (!rst_n) begin
            stub_cnt = 0;
        end else if (start_f) begin
            stub_cnt = 3;
        end else if (stub_cnt > 0 && !stub_hold) begin
            stub_cnt = stub_cnt - 1;
            if (stub_cnt == 0) done_f = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] df, output logic [31:0] dr);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        df = rdata_f; dr = rdata_r;
        bus_valid = 1'b0;
    endtask

    // Legal table from R4: returns code, or -1 when illegal
    function automatic int exp_code(input int base, input int vari);
        if (vari == 0 && base == 0) return 0;
        if (vari == 0 && base == 2) return 1;
        if (vari == 0 && base == 4) return 2;
        if (vari == 0 && base == 5) return 3;
        if (vari == 0 && base == 6) return 4;
        if (vari == 1 && base == 6) return 5;
        if (vari == 2 && base == 6) return 6;
        return -1;
    endfunction

    task automatic finish_and_ack();
        logic [31:0] f, r;
        repeat (6) @(negedge clk);
        wr(12'h01C, 32'h0000_0200);
        rd(12'h01C, f, r);
        chk("R7 status after ack", f, 32'h0);
    endtask

    bit done_flag_tb = 1'b0;

    initial begin
        logic [31:0] f, r;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq at reset", {31'b0, irq_f}, 32'h0);
        chk("R1 start at reset", {31'b0, start_f}, 32'h0);
        rst_n = 1'b1;
        for (int w = 0; w < 16; w++) begin
            rd(12'(w * 4), f, r);
            chk("R1 word reads 0 after reset", f, 32'h0);
        end

        // R2: per-register write masks
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h024, 32'hFFFF_FFFF);
        wr(12'h02C, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h020, f, r); chk("R2 source mask", f, 32'h7FFF_FFFF);
        rd(12'h024, f, r); chk("R2 destination mask", f, 32'h7FFF_FFF8);
        rd(12'h02C, f, r); chk("R2 length mask", f, 32'h0FFF_FFFF);
        rd(12'h010, f, r); chk("R2 cipher command full width", f, 32'hFFFF_FFFF);

        // R3: out-of-range and unmapped words
        wr(12'h060, 32'hA5A5_A5A5);
        rd(12'h020, f, r); chk("R3 no alias from word 24", f, 32'h7FFF_FFFF);
        rd(12'h060, f, r); chk("R3 out-of-range read", f, 32'h0);
        wr(12'h3FC, 32'h1234_5678);
        rd(12'h3FC, f, r); chk("R3 top word read", f, 32'h0);
        wr(12'h014, 32'h5555_5555);
        rd(12'h014, f, r); chk("R3 unmapped in-range read", f, 32'h0);
        rd(12'h01C, f, r); chk("R3 status untouched", f, 32'h0);

        // R5: launch presents register values
        wr(12'h020, 32'h0000_1000);
        wr(12'h024, 32'h0000_2003);
        wr(12'h02C, 32'h0000_0040);
        wr(12'h030, 32'h0004_0050);
        chk("R5 start pulse", {31'b0, start_f}, 32'h1);
        chk("R5 algo code sha256", {29'b0, algo_f}, 32'h3);
        chk("R5 sg bit", {31'b0, sg_f}, 32'h1);
        chk("R5 job src", src_f, 32'h0000_1000);
        chk("R5 job dst aligned", dst_f, 32'h0000_2000);
        chk("R5 job len", len_f, 32'h0000_0040);
        @(negedge clk);
        chk("R5 start lasts one cycle", {31'b0, start_f}, 32'h0);
        finish_and_ack();

        // R4 sweep over every base/variant pair, interrupt disabled
        for (int v = 0; v < 8; v++) begin
            for (int s = 0; s < 8; s++) begin
                int code;
                logic [31:0] cmd;
                code = exp_code(s, v);
                cmd = (32'(v) << 10) | (32'(s) << 4);
                wr(12'h030, cmd);
                chk("R4 start matches legality", {31'b0, start_f}, (code >= 0) ? 32'h1 : 32'h0);
                chk("R4 error flag", {31'b0, err_f}, (code >= 0) ? 32'h0 : 32'h1);
                chk("R9 no unsupported flag", {31'b0, uns_f}, 32'h0);
                if (code >= 0) chk("R4 algo code", {29'b0, algo_f}, 32'(code));
                repeat (6) @(negedge clk);
                rd(12'h01C, f, r);
                chk("R6 status after command", f, (code >= 0) ? 32'h0000_0200 : 32'h0);
                chk("R6 irq stays low when disabled", {31'b0, irq_f}, 32'h0);
                rd(12'h030, f, r);
                chk("R10 command stored", f, cmd);
                wr(12'h01C, 32'h0000_0200);
            end
        end

        // R8: commands ignored while busy
        stub_hold = 1'b1;
        wr(12'h030, 32'h0000_0020);
        chk("R8 first start", {31'b0, start_f}, 32'h1);
        rd(12'h01C, f, r); chk("R8 busy bit", f, 32'h0000_0001);
        wr(12'h030, 32'h0000_0040);
        chk("R8 no start while busy", {31'b0, start_f}, 32'h0);
        wr(12'h030, 32'h0000_00F0);
        chk("R8 no error while busy", {31'b0, err_f}, 32'h0);
        rd(12'h030, f, r); chk("R8 command unchanged", f, 32'h0000_0020);
        stub_hold = 1'b0;
        repeat (6) @(negedge clk);
        rd(12'h01C, f, r); chk("R6 done after stall", f, 32'h0000_0200);
        wr(12'h01C, 32'h0000_0200);

        // R6/R7: interrupt path
        wr(12'h030, 32'h0000_0250);
        repeat (6) @(negedge clk);
        chk("R6 irq raised when enabled", {31'b0, irq_f}, 32'h1);
        wr(12'h01C, 32'h0000_0000);
        chk("R7 write of 0 keeps irq", {31'b0, irq_f}, 32'h1);
        rd(12'h01C, f, r); chk("R7 write of 0 keeps done", f, 32'h0000_0200);
        wr(12'h01C, 32'h0000_0200);
        chk("R7 ack lowers irq", {31'b0, irq_f}, 32'h0);
        rd(12'h01C, f, r); chk("R7 ack clears done", f, 32'h0);

        // R9: unsupported modes still launch
        wr(12'h030, 32'h0000_01A0);
        chk("R9 keyed mode flagged", {31'b0, uns_f}, 32'h1);
        chk("R9 keyed mode still starts", {31'b0, start_f}, 32'h1);
        finish_and_ack();
        wr(12'h030, 32'h0000_0022);
        chk("R9 chained mode flagged", {31'b0, uns_f}, 32'h1);
        chk("R9 chained mode still starts", {31'b0, start_f}, 32'h1);
        finish_and_ack();

        // R2: variant mask on the command word
        wr(12'h030, 32'h0004_0460);
        chk("R2 full: sha384 code", {29'b0, algo_f}, 32'h5);
        chk("R2 full: sg kept", {31'b0, sg_f}, 32'h1);
        chk("R2 reduced: starts", {31'b0, start_r}, 32'h1);
        chk("R2 reduced: variant masked to sha512", {29'b0, algo_r}, 32'h4);
        chk("R2 reduced: sg masked", {31'b0, sg_r}, 32'h0);
        rd(12'h030, f, r);
        chk("R2 full command readback", f, 32'h0004_0460);
        chk("R2 reduced command readback", r, 32'h0000_0060);
        finish_and_ack();

        if (!done_flag_tb) begin
            done_flag_tb = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag_tb) begin
            done_flag_tb = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule